// File: doc/BRIEF.md
# Shared-Bus Four-DAC Update Sequencer

This block feeds four 16-bit converters that share a single 16-bit data bus. Three converters capture their word from the bus through their own latch, and the fourth reads the bus directly. For every converter, the block adds three signed contributions: a DC trim, a signal-generator sample and a controller output. It clamps the sum to the signed 16-bit range. It then plays the four words onto the bus in a fixed order, pulsing each latch in turn. The fourth word is left driven on the bus while the conversion clocks fire.

Updates are paced by a free-running period counter, set through a parameter in system clock cycles. A default of 31 cycles at 250 MHz gives about 8 Msps. An update request is remembered and starts a sequence at the next period boundary. The three contributions, the mode and the mask are all sampled at that boundary. In simultaneous mode, all four conversion clocks pulse together. In independent mode, only the converters selected by the mask get a pulse.

Top module: `dac_bus_sequencer`

## Requirements
- R1: While reset is held and after it is released with no request, `bus_o`, `latch_o` and `conv_o` are all zero.
- R2: The word for converter k is trim + generator + controller, taking each input as a signed 16-bit slice k (bits 16k+15..16k) and summing at 18 bits.
- R3: A sum above 32767 is driven as 32767 (0x7FFF), and a sum below -32768 is driven as -32768 (0x8000). Sums inside the range pass through unchanged.
- R4: Within one sequence the latch strobes fire in the order `latch_o[0]`, `latch_o[1]`, `latch_o[2]`. Each strobe lasts one cycle and no two strobes are ever high together.
- R5: The bus carries the word of converter k on the cycle before, the cycle of, and the cycle after the strobe of `latch_o[k]`.
- R6: Conversion clocks pulse for one cycle, exactly three cycles after the `latch_o[2]` strobe. The bus carries the word of converter 3 on that cycle and on the cycle before it. No conversion clock pulses at any other time.
- R7: With `sync_mode_i` = 1 at the start of a sequence, all four bits of `conv_o` pulse in the same cycle, whatever the mask.
- R8: With `sync_mode_i` = 0, `conv_o` bit k pulses only if `conv_mask_i` bit k was 1 at the start. A zero mask runs the latch sequence but pulses no conversion clock.
- R9: A sequence starts only at period boundaries, so sequence starts are always whole multiples of the period apart.
- R10: A request that arrives while a sequence is running is held and serviced at the next boundary. Any number of requests during one run lead to exactly one further sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_req_i | input | 1 | Update request pulse |
| sync_mode_i | input | 1 | 1: all conversion clocks together; 0: masked, independent |
| conv_mask_i | input | 4 | Per-converter conversion clock enable (independent mode) |
| trim_i | input | 64 | Four signed DC trim words, converter k in bits 16k+15..16k |
| gen_i | input | 64 | Four signed signal-generator words |
| ctl_i | input | 64 | Four signed controller words |
| bus_o | output | 16 | Shared converter data bus |
| latch_o | output | 3 | Latch strobes for converters 0..2 |
| conv_o | output | 4 | Conversion clocks for converters 0..3 |

## Verification
The hardest case to reach is a request that lands while a sequence is already in flight. It must be neither lost nor duplicated, and the next run must start exactly one period later. The bench waits until the monitor sees the first latch strobe of a run. It then pulses the request twice in a row. After that it watches for exactly one more sequence, spaced one full period from the first, with no extra sequence in the idle time that follows. The saturation corners are reached by driving all three summands to their extremes, and also to values that land exactly on and just past the limits.

// File: rtl/dacseq_pkg.sv
// Package: shared types for the shared-bus converter sequencer.
// Assumes nothing beyond the phase encoding being local to this block.
package dacseq_pkg;
    // Sub-step inside one converter slot of the sequence.
    typedef enum logic [1:0] {
        PH_SETUP  = 2'd0,
        PH_STROBE = 2'd1,
        PH_HOLD   = 2'd2
    } phase_e;

    // Guard bits added to the summation width (three addends).
    localparam int unsigned SUM_GUARD = 2;
endpackage

// File: rtl/dacseq_word_former.sv
// Module: forms each converter word as the sum of three signed
// contributions and clamps it to the signed DATA_W range.
// Assumes all inputs are two's complement, slice k = converter k.
module dacseq_word_former
    import dacseq_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned N_DAC  = 4
) (
    input  logic [N_DAC*DATA_W-1:0] trim_i,
    input  logic [N_DAC*DATA_W-1:0] gen_i,
    input  logic [N_DAC*DATA_W-1:0] ctl_i,
    output logic [N_DAC*DATA_W-1:0] word_o
);
    localparam int unsigned SUM_W = DATA_W + SUM_GUARD;
    localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((1 << (DATA_W-1)) - 1);
    localparam logic signed [SUM_W-1:0] SAT_LO = -SAT_HI - SUM_W'(1);

    for (genvar g = 0; g < N_DAC; g++) begin : g_dac
        logic signed [SUM_W-1:0] sum;

        // Widen each addend by sign extension and add at full width.
        always_comb begin
            sum = SUM_W'($signed(trim_i[g*DATA_W +: DATA_W]))
                + SUM_W'($signed(gen_i[g*DATA_W +: DATA_W]))
                + SUM_W'($signed(ctl_i[g*DATA_W +: DATA_W]));
        end

        // Clamp the wide sum into the converter's signed range.
        always_comb begin
            if (sum > SAT_HI) begin
                word_o[g*DATA_W +: DATA_W] = SAT_HI[DATA_W-1:0];
            end else if (sum < SAT_LO) begin
                word_o[g*DATA_W +: DATA_W] = SAT_LO[DATA_W-1:0];
            end else begin
                word_o[g*DATA_W +: DATA_W] = sum[DATA_W-1:0];
            end
        end
    end
endmodule

// File: rtl/dacseq_period_timer.sv
// Module: free-running counter that marks the last cycle of each
// update period. Assumes PERIOD >= 2.
module dacseq_period_timer #(
    parameter int unsigned PERIOD = 31
) (
    input  logic clk,
    input  logic rst_n,
    output logic boundary_o
);
    localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    // Count 0..PERIOD-1 and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // Flag the final count of the period.
    always_comb boundary_o = (cnt_q == LAST);

    AST_BOUNDARY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        boundary_o |=> (cnt_q == '0)); // R9
endmodule

// File: rtl/dacseq_step_engine.sv
// Module: holds a pending request, snapshots the words at a period
// boundary and steps the bus, latch strobes and conversion clocks.
// Assumes the first N_DAC-1 converters are latched and the last one
// reads the bus directly, and that a sequence fits in one period.
module dacseq_step_engine
    import dacseq_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned N_DAC  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    boundary_i,
    input  logic                    upd_req_i,
    input  logic                    sync_mode_i,
    input  logic [N_DAC-1:0]        conv_mask_i,
    input  logic [N_DAC*DATA_W-1:0] word_i,
    output logic [DATA_W-1:0]       bus_o,
    output logic [N_DAC-2:0]        latch_o,
    output logic [N_DAC-1:0]        conv_o
);
    localparam int unsigned N_LAT = N_DAC - 1;
    localparam int unsigned GW    = $clog2(N_DAC);
    localparam logic [GW-1:0] LAST_GRP = GW'(N_LAT);

    logic                 pending_q;
    logic                 running_q;
    logic [GW-1:0]        grp_q;
    phase_e               ph_q;
    logic                 sync_q;
    logic [N_DAC-1:0]     mask_q;
    logic [DATA_W-1:0]    snap_q [N_DAC];
    logic                 start;
    logic [DATA_W-1:0]    bus_d;
    logic [N_LAT-1:0]     latch_d;
    logic [N_DAC-1:0]     conv_d;

    // Launch a sequence at a boundary when one is owed and none runs.
    always_comb start = boundary_i && pending_q && !running_q;

    // Remember requests until a sequence launches; new ones win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
        end else begin
            pending_q <= upd_req_i || (pending_q && !start);
        end
    end

    // Capture words, mode and mask at launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
            mask_q <= '0;
            for (int k = 0; k < N_DAC; k++) snap_q[k] <= '0;
        end else if (start) begin
            sync_q <= sync_mode_i;
            mask_q <= conv_mask_i;
            for (int k = 0; k < N_DAC; k++) snap_q[k] <= word_i[k*DATA_W +: DATA_W];
        end
    end

    // Walk the slot and phase counters through the sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            grp_q     <= '0;
            ph_q      <= PH_SETUP;
        end else if (start) begin
            running_q <= 1'b1;
            grp_q     <= '0;
            ph_q      <= PH_SETUP;
        end else if (running_q) begin
            if (grp_q == LAST_GRP) begin
                if (ph_q == PH_STROBE) running_q <= 1'b0;
                else ph_q <= PH_STROBE;
            end else if (ph_q == PH_HOLD) begin
                ph_q  <= PH_SETUP;
                grp_q <= grp_q + GW'(1);
            end else begin
                ph_q <= (ph_q == PH_SETUP) ? PH_STROBE : PH_HOLD;
            end
        end
    end

    // Decode the next bus word, strobes and clocks from the step.
    always_comb begin
        bus_d   = bus_o;
        latch_d = '0;
        conv_d  = '0;
        if (running_q) begin
            if (grp_q == LAST_GRP) begin
                bus_d = snap_q[N_DAC-1];
                if (ph_q == PH_STROBE) conv_d = sync_q ? {N_DAC{1'b1}} : mask_q;
            end else begin
                for (int k = 0; k < N_LAT; k++) begin
                    if (grp_q == GW'(k)) begin
                        bus_d      = snap_q[k];
                        latch_d[k] = (ph_q == PH_STROBE);
                    end
                end
            end
        end
    end

    // Register every pin driven toward the converters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_o   <= '0;
            latch_o <= '0;
            conv_o  <= '0;
        end else begin
            bus_o   <= bus_d;
            latch_o <= latch_d;
            conv_o  <= conv_d;
        end
    end

    AST_LATCH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(latch_o)); // R4
    AST_BUS_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_o != '0) |-> $stable(bus_o)); // R5
    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_o != '0) |=> $stable(bus_o)); // R5
    AST_CONV_AFTER_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_o != '0) |-> ($past(latch_o[N_LAT-1], 3) && $stable(bus_o))); // R6
    AST_CONV_SYNC_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        ((conv_o != '0) && sync_q) |-> (&conv_o)); // R7
    AST_CONV_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((conv_o != '0) && !sync_q) |-> ((conv_o & ~mask_q) == '0)); // R8
    AST_SEQ_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        boundary_i |-> !running_q); // R9
endmodule

// File: rtl/dac_bus_sequencer.sv
// Module: top of the shared-bus converter update sequencer. Joins the
// word former, the period timer and the step engine.
// Assumes PERIOD exceeds the sequence length (3*(N_DAC-1)+3 cycles).
module dac_bus_sequencer #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned N_DAC  = 4,
    parameter int unsigned PERIOD = 31
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd_req_i,
    input  logic                    sync_mode_i,
    input  logic [N_DAC-1:0]        conv_mask_i,
    input  logic [N_DAC*DATA_W-1:0] trim_i,
    input  logic [N_DAC*DATA_W-1:0] gen_i,
    input  logic [N_DAC*DATA_W-1:0] ctl_i,
    output logic [DATA_W-1:0]       bus_o,
    output logic [N_DAC-2:0]        latch_o,
    output logic [N_DAC-1:0]        conv_o
);
    logic [N_DAC*DATA_W-1:0] word;
    logic                    boundary;

    dacseq_word_former #(.DATA_W(DATA_W), .N_DAC(N_DAC)) u_former (
        .trim_i (trim_i),
        .gen_i  (gen_i),
        .ctl_i  (ctl_i),
        .word_o (word)
    );

    dacseq_period_timer #(.PERIOD(PERIOD)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .boundary_o (boundary)
    );

    dacseq_step_engine #(.DATA_W(DATA_W), .N_DAC(N_DAC)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .boundary_i  (boundary),
        .upd_req_i   (upd_req_i),
        .sync_mode_i (sync_mode_i),
        .conv_mask_i (conv_mask_i),
        .word_i      (word),
        .bus_o       (bus_o),
        .latch_o     (latch_o),
        .conv_o      (conv_o)
    );
endmodule

// File: tb/dac_bus_sequencer_bench.sv
// Scoreboard bench: the driver pushes expected words and clocks into a
// queue, the monitor pops an entry at each first strobe and follows it.
module dac_bus_sequencer_bench;
    localparam int PERIOD = 31;

    typedef struct packed {
        logic [63:0] words;
        logic [3:0]  conv;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_req = 1'b0;
    logic        sync_mode = 1'b0;
    logic [3:0]  conv_mask = '0;
    logic [63:0] trim = '0, gen = '0, ctl = '0;
    logic [15:0] bus;
    logic [2:0]  latch;
    logic [3:0]  conv;

    int n_checks = 0;
    int n_fail = 0;
    exp_t q[$];
    exp_t cur;
    int cyc = 0;
    int starts = 0;
    int first_start = -1;
    int prev_start = 0;
    int last_start = 0;

    dac_bus_sequencer #(.DATA_W(16), .N_DAC(4), .PERIOD(PERIOD)) u_dac_bus_sequencer (
        .clk(clk), .rst_n(rst_n), .upd_req_i(upd_req), .sync_mode_i(sync_mode),
        .conv_mask_i(conv_mask), .trim_i(trim), .gen_i(gen), .ctl_i(ctl),
        .bus_o(bus), .latch_o(latch), .conv_o(conv)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] sat16(input logic [15:0] a, input logic [15:0] b,
                                          input logic [15:0] c);
        int s;
        s = int'($signed(a)) + int'($signed(b)) + int'($signed(c));
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        return s[15:0];
    endfunction

    // Monitor: follows each sequence at the ports, away from the edge.
    bit          hold_chk = 0;
    logic [15:0] hold_val = '0;
    logic [15:0] prev_bus = '0;
    int          next_lat = 0;
    bit          armed = 0;
    int          age = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (hold_chk) begin
                chk(bus == hold_val, "R5", "bus after strobe", bus, hold_val);
                hold_chk = 0;
            end
            if (armed) begin
                age++;
                if (age < 3) chk(conv == 4'd0, "R6", "early conv", conv, 0);
                if (age >= 2) chk(bus == cur.words[63:48], "R6", "bus word3", bus, cur.words[63:48]);
                if (age == 3) begin
                    chk(conv == cur.conv, "R7/R8", "conv clocks", conv, cur.conv);
                    armed = 0;
                end
            end else if (conv != 4'd0) begin
                chk(0, "R6", "stray conv", conv, 0);
            end
            if (!$onehot0(latch)) chk(0, "R4", "strobes overlap", latch, 0);
            if (latch != 3'd0) begin
                hold_chk = 1;
                hold_val = bus;
                chk(prev_bus == bus, "R5", "bus before strobe", prev_bus, bus);
            end
            if (latch == 3'b001) begin
                if (q.size() == 0) begin
                    chk(0, "R10", "sequence without request", starts, -1);
                end else begin
                    cur = q.pop_front();
                end
                starts++;
                prev_start = last_start;
                last_start = cyc;
                if (first_start < 0) first_start = cyc;
                chk((cyc - first_start) % PERIOD == 0, "R9", "start off boundary",
                    (cyc - first_start) % PERIOD, 0);
                chk(bus == cur.words[15:0], "R2", "word0", bus, cur.words[15:0]);
                next_lat = 1;
            end else if (latch == 3'b010) begin
                chk(next_lat == 1, "R4", "latch1 order", next_lat, 1);
                chk(bus == cur.words[31:16], "R2", "word1", bus, cur.words[31:16]);
                next_lat = 2;
            end else if (latch == 3'b100) begin
                chk(next_lat == 2, "R4", "latch2 order", next_lat, 2);
                chk(bus == cur.words[47:32], "R3", "word2", bus, cur.words[47:32]);
                next_lat = 0;
                armed = 1;
                age = 0;
            end
            prev_bus = bus;
        end
    end

    // Driver: set summands, push the expected item, pulse the request.
    task automatic load(input logic [63:0] tr, input logic [63:0] gn,
                        input logic [63:0] ct, input bit sm, input logic [3:0] mk,
                        input int copies);
        exp_t e;
        @(negedge clk);
        trim = tr; gen = gn; ctl = ct; sync_mode = sm; conv_mask = mk;
        for (int k = 0; k < 4; k++)
            e.words[k*16 +: 16] = sat16(tr[k*16 +: 16], gn[k*16 +: 16], ct[k*16 +: 16]);
        e.conv = sm ? 4'hF : mk;
        for (int i = 0; i < copies; i++) q.push_back(e);
        upd_req = 1'b1;
        @(negedge clk);
        upd_req = 1'b0;
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        repeat (14) @(negedge clk);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(bus == 16'd0, "R1", "bus in reset", bus, 0);
        chk(latch == 3'd0, "R1", "latch in reset", latch, 0);
        chk(conv == 4'd0, "R1", "conv in reset", conv, 0);
        rst_n = 1'b1;
        repeat (2 * PERIOD) @(negedge clk);
        chk(bus == 16'd0 && latch == 3'd0 && conv == 4'd0, "R1", "idle after reset",
            {bus, latch, conv}, 0);

        // R2 / R7: plain sums, simultaneous mode ignores a zero mask.
        load({16'd400, 16'd300, 16'd200, 16'd100}, {16'd4, 16'd3, 16'd2, 16'd1},
             {-16'sd5, -16'sd6, 16'd7, -16'sd1000}, 1'b1, 4'b0000, 1);
        drain();
        // R8: independent mode, mask 0101.
        load({16'h1234, 16'h0F00, 16'hFFFF, 16'h0001}, 64'd0,
             {16'd1, 16'd2, 16'd3, 16'd4}, 1'b0, 4'b0101, 1);
        drain();
        // R3: saturation corners (max, min, exactly max, one past max).
        load({16'd30000, 16'h7FFF, 16'h8000, 16'h7FFF},
             {16'd2767, 16'd1, 16'h8000, 16'h7FFF},
             {16'd1, 16'hFFFF, 16'h8000, 16'h7FFF}, 1'b1, 4'b0000, 1);
        drain();
        // R3: negative edge exactly -32768 and just below.
        load({16'h8000, 16'h8001, 16'hC000, 16'h8000},
             {16'h0000, 16'hFFFF, 16'hC000, 16'hFFFF},
             {16'h0000, 16'h0000, 16'hFFFF, 16'h0000}, 1'b0, 4'b1000, 1);
        drain();
        // R8: zero mask in independent mode fires no clock.
        load({16'd9, 16'd8, 16'd7, 16'd6}, 64'd0, 64'd0, 1'b0, 4'b0000, 1);
        drain();

        // R10: two requests while a run is in flight give exactly one more run.
        begin
            int s0;
            s0 = starts;
            load({16'd11, 16'd22, 16'd33, 16'd44}, {16'd5, 16'd5, 16'd5, 16'd5},
                 64'd0, 1'b0, 4'b0110, 2);
            while (starts == s0) @(negedge clk);
            upd_req = 1'b1;
            repeat (2) @(negedge clk);
            upd_req = 1'b0;
            drain();
            chk(starts == s0 + 2, "R10", "held-over run count", starts - s0, 2);
            chk(last_start - prev_start == PERIOD, "R9", "held-over spacing",
                last_start - prev_start, PERIOD);
            repeat (3 * PERIOD) @(negedge clk);
            chk(starts == s0 + 2, "R10", "no extra run", starts - s0, 2);
        end
        report();
    end

    initial begin
        repeat (150000) @(negedge clk);
        chk(0, "WDOG", "watchdog expired", 0, 1);
        report();
    end
endmodule